// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Sequencer

This block changes a PLL's counter settings at run time by writing a new configuration image into the PLL's serial scan chain. A start pulse makes it read the image one bit at a time from a small local ROM that was loaded with the desired settings. The image goes into the PLL scan-data input with the highest-numbered bit first and bit 0 last. The block then requests the update and waits for the PLL to report that the scan has completed. After that it gives the PLL one cycle of asynchronous reset, which the PLL needs before it can lock again, and then waits for lock before it reports completion.

Some PLLs raise scan-done after the first reconfiguration and never lower it again. The sequencer therefore reacts only to a rising edge of scan-done. If scan-done is already high when the update is issued, it waits a fixed number of clocks instead. A timeout on the lock wait stops the run with an error flag, so the block cannot hang.

The state machine has seven states. IDLE waits for start. PREFETCH presents the first ROM address. SHIFT clocks the image out. UPDATE issues the update strobe and samples scan-done. WAIT_DONE waits for a scan-done rising edge, or for the fixed count. RESET_PLL drives the reset pulse. WAIT_LOCK waits for lock or for the timeout. The transitions are:
- IDLE→PREFETCH when start is seen.
- PREFETCH→SHIFT unconditionally.
- SHIFT→UPDATE after the last bit.
- UPDATE→WAIT_DONE unconditionally.
- WAIT_DONE→RESET_PLL on the qualified scan-done.
- RESET_PLL→WAIT_LOCK unconditionally.
- WAIT_LOCK→IDLE on lock, which raises done, or on timeout, which raises the error flag.

Top module: `pll_scan_seq`

## Requirements
- R1: During and after reset, busy_o, done_o, err_o, scan_clk_en_o, update_o and pll_areset_o are all 0.
- R2: After an accepted start, scan_clk_en_o is high for exactly CHAIN_LEN (144) consecutive clock cycles.
- R3: In the j-th enabled cycle (j counted from 0), scan_data_o equals image bit CHAIN_LEN-1-j. rom_addr_o carries the bit index, and the ROM returns that bit one clock later.
- R4: update_o is a single-cycle pulse in the cycle right after the last enabled cycle, and scan_clk_en_o is low during that pulse.
- R5: If scan_done_i is low in the update cycle, pll_areset_o is asserted in the cycle after the first cycle in which scandone_i is high.
- R6: If scandone_i is already high in the update cycle, pll_areset_o is asserted exactly DONE_WAIT+1 cycles after the update cycle.
- R7: pll_areset_o is high for exactly one cycle, once per run.
- R8: done_o is a one-cycle pulse in the cycle after locked_i is first seen high following the reset pulse. busy_o is low in that cycle, and err_o stays low.
- R9: If locked_i stays low, err_o pulses LOCK_TIMEOUT+1 cycles after the reset pulse, busy_o falls, no done_o is given, and the next start runs normally.
- R10: busy_o rises in the cycle after an accepted start. A start while busy_o is high is ignored, so one run yields exactly CHAIN_LEN enabled cycles and one done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only in IDLE |
| busy_o | output | 1 | A reconfiguration run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle lock-timeout pulse |
| rom_addr_o | output | $clog2(CHAIN_LEN) | Bit index presented to the image ROM |
| rom_data_i | input | 1 | ROM bit, one cycle after its address |
| scan_data_o | output | 1 | Serial data into the PLL chain |
| scan_clk_en_o | output | 1 | Scan clock enable, high while a bit is valid |
| update_o | output | 1 | Update strobe to the PLL |
| pll_areset_o | output | 1 | PLL asynchronous reset pulse |
| scandone_i | input | 1 | PLL scan-done indication |
| locked_i | input | 1 | PLL lock indication |

## Verification
Images include one with only bit 143 set. A sequencer that shifted bit 0 first, or that lost the ROM latency, would put that lone one in the wrong enabled cycle and would show 145 or 143 enables. A PLL model whose scan-done stays high is driven through repeated runs. A design that treated the old high level as completion would pulse reset two cycles after the update instead of DONE_WAIT+1 cycles, and a design that waited for scan-done to fall would hang. Other runs leave lock low, to show the error path and the recovery after it. Further runs pulse start in the middle of a shift; a design that restarted on that pulse would emit extra enabled cycles or a second done.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFETCH,
        ST_SHIFT,
        ST_UPDATE,
        ST_WAIT_DONE,
        ST_RESET_PLL,
        ST_WAIT_LOCK
    } seq_state_e;

endpackage

// File: rtl/pll_scan_shift.sv
// Bit-address walker: counts the image index down and the shifted bits up.
module pll_scan_shift #(
    parameter int CHAIN_LEN = 144,
    localparam int AW = $clog2(CHAIN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          shifting,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= AW'(CHAIN_LEN - 1);
            cnt_q  <= '0;
        end else begin
            if (adv) begin
                addr_q <= addr_q - AW'(1);
            end
            if (shifting) begin
                cnt_q <= cnt_q + AW'(1);
            end
        end
    end

    assign addr = addr_q;
    assign last = shifting && (cnt_q == AW'(CHAIN_LEN - 1));
endmodule

// File: rtl/pll_scan_done_qual.sv
// Scan-done qualifier: a rising edge when the level was low at update,
// otherwise a fixed wait of DONE_WAIT cycles.
module pll_scan_done_qual #(
    parameter int DONE_WAIT = 16,
    localparam int NW = $clog2(DONE_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scandone,
    input  logic arm,
    input  logic waiting,
    output logic hit
);
    logic          sd_q;
    logic          stuck_q;
    logic [NW-1:0] wcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q    <= 1'b0;
            stuck_q <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            sd_q <= scandone;
            if (arm) begin
                stuck_q <= scandone;
                wcnt_q  <= '0;
            end else if (waiting) begin
                wcnt_q <= wcnt_q + NW'(1);
            end
        end
    end

    always_comb begin
        if (!waiting) begin
            hit = 1'b0;
        end else if (stuck_q) begin
            hit = (wcnt_q == NW'(DONE_WAIT - 1));
        end else begin
            hit = scandone && !sd_q;
        end
    end
endmodule

// File: rtl/pll_scan_timer.sv
// Lock-wait timeout counter.
module pll_scan_timer #(
    parameter int LOCK_TIMEOUT = 4096,
    localparam int TW = $clog2(LOCK_TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (clear) begin
            tcnt_q <= '0;
        end else if (run) begin
            tcnt_q <= tcnt_q + TW'(1);
        end
    end

    assign expired = run && (tcnt_q == TW'(LOCK_TIMEOUT - 1));
endmodule

// File: rtl/pll_scan_seq.sv
module pll_scan_seq #(
    parameter int CHAIN_LEN    = 144,
    parameter int DONE_WAIT    = 16,
    parameter int LOCK_TIMEOUT = 4096,
    localparam int AW = $clog2(CHAIN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [AW-1:0] rom_addr_o,
    input  logic          rom_data_i,
    output logic          scan_data_o,
    output logic          scan_clk_en_o,
    output logic          update_o,
    output logic          pll_areset_o,
    input  logic          scandone_i,
    input  logic          locked_i
);
    import pll_scan_pkg::*;

    seq_state_e state_q;
    logic       done_q;
    logic       err_q;
    logic       load;
    logic       adv;
    logic       shifting;
    logic       last_bit;
    logic       arm;
    logic       waiting;
    logic       sd_hit;
    logic       lk_clear;
    logic       lk_run;
    logic       lk_expired;

    pll_scan_shift #(.CHAIN_LEN(CHAIN_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .shifting (shifting),
        .addr     (rom_addr_o),
        .last     (last_bit)
    );

    pll_scan_done_qual #(.DONE_WAIT(DONE_WAIT)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .scandone (scandone_i),
        .arm      (arm),
        .waiting  (waiting),
        .hit      (sd_hit)
    );

    pll_scan_timer #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (lk_clear),
        .run     (lk_run),
        .expired (lk_expired)
    );

    // State register with the completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_PREFETCH;
                    end
                end
                ST_PREFETCH: begin
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        state_q <= ST_UPDATE;
                    end
                end
                ST_UPDATE: begin
                    state_q <= ST_WAIT_DONE;
                end
                ST_WAIT_DONE: begin
                    if (sd_hit) begin
                        state_q <= ST_RESET_PLL;
                    end
                end
                ST_RESET_PLL: begin
                    state_q <= ST_WAIT_LOCK;
                end
                ST_WAIT_LOCK: begin
                    if (locked_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (lk_expired) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        load          = 1'b0;
        adv           = 1'b0;
        shifting      = 1'b0;
        arm           = 1'b0;
        waiting       = 1'b0;
        lk_clear      = 1'b0;
        lk_run        = 1'b0;
        busy_o        = 1'b1;
        scan_clk_en_o = 1'b0;
        scan_data_o   = 1'b0;
        update_o      = 1'b0;
        pll_areset_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load   = start_i;
            end
            ST_PREFETCH: begin
                adv = 1'b1;
            end
            ST_SHIFT: begin
                adv           = 1'b1;
                shifting      = 1'b1;
                scan_clk_en_o = 1'b1;
                scan_data_o   = rom_data_i;
            end
            ST_UPDATE: begin
                update_o = 1'b1;
                arm      = 1'b1;
            end
            ST_WAIT_DONE: begin
                waiting = 1'b1;
            end
            ST_RESET_PLL: begin
                pll_areset_o = 1'b1;
                lk_clear     = 1'b1;
            end
            ST_WAIT_LOCK: begin
                lk_run = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/pll_scan_seq_chk.sv
module pll_scan_seq_chk #(
    parameter int CHAIN_LEN = 144,
    localparam int RW = $clog2(CHAIN_LEN + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic scan_clk_en_o,
    input logic update_o,
    input logic pll_areset_o
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (scan_clk_en_o) begin
            if (run_q != RW'(CHAIN_LEN + 1)) begin
                run_q <= run_q + RW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    assert_en_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_clk_en_o && run_q != '0) |-> (run_q == RW'(CHAIN_LEN)));

    assert_en_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clk_en_o |-> busy_o);

    assert_update_after_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (!scan_clk_en_o && $past(scan_clk_en_o)));

    assert_update_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    assert_areset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_areset_o |=> !pll_areset_o);

    assert_areset_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_areset_o |-> busy_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !err_o));

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind pll_scan_seq pll_scan_seq_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .scan_clk_en_o (scan_clk_en_o),
    .update_o      (update_o),
    .pll_areset_o  (pll_areset_o)
);

// File: tb/tb_pll_scan_seq.sv
`timescale 1ns/1ps
module tb_pll_scan_seq;
    localparam int CH = 144;
    localparam int NW = 12;
    localparam int TO = 200;
    localparam int AW = $clog2(CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, err, sdata, sen, upd, arst;
    logic [AW-1:0] raddr;
    logic rom_q = 1'b0;
    logic scandone = 1'b0;
    logic locked = 1'b1;

    always #4 clk = ~clk;

    pll_scan_seq #(.CHAIN_LEN(CH), .DONE_WAIT(NW), .LOCK_TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .err_o(err), .rom_addr_o(raddr), .rom_data_i(rom_q), .scan_data_o(sdata),
        .scan_clk_en_o(sen), .update_o(upd), .pll_areset_o(arst),
        .scandone_i(scandone), .locked_i(locked)
    );

    // Image ROM, one-cycle read latency
    logic [CH-1:0] img;
    always @(posedge clk) rom_q <= (int'(raddr) < CH) ? img[raddr] : 1'b0;

    // Behavioural PLL model
    int sd_dly = 3, lk_dly = 3, sd_cnt = 0, lk_cnt = 0;
    bit sticky = 1'b0;
    always @(posedge clk) begin
        if (sen && !sticky) scandone <= 1'b0;
        if (upd) sd_cnt <= sd_dly;
        else if (sd_cnt != 0) begin
            sd_cnt <= sd_cnt - 1;
            if (sd_cnt == 1) scandone <= 1'b1;
        end
        if (arst) begin
            locked <= 1'b0;
            lk_cnt <= lk_dly;
        end else if (lk_cnt != 0) begin
            lk_cnt <= lk_cnt - 1;
            if (lk_cnt == 1) locked <= 1'b1;
        end
    end

    // Monitor
    int cyc = 0, en_cnt, first_en, last_en, upd_cnt, upd_cyc, ar_cnt, ar_cyc;
    int done_cnt, done_cyc, err_cnt, err_cyc;
    bit upd_en_low, busy_at_end;
    logic [CH-1:0] cap;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sen) begin
            if (en_cnt == 0) first_en = cyc;
            last_en = cyc;
            if (en_cnt < CH) cap[CH-1-en_cnt] = sdata;
            en_cnt = en_cnt + 1;
        end
        if (upd) begin upd_cnt++; upd_cyc = cyc; upd_en_low = !sen; end
        if (arst) begin ar_cnt++; ar_cyc = cyc; end
        if (done) begin done_cnt++; done_cyc = cyc; busy_at_end = busy; end
        if (err) begin err_cnt++; err_cyc = cyc; busy_at_end = busy; end
    end

    int nchk = 0, nfail = 0;
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_image(input int seed);
        for (int i = 0; i < CH; i++) begin
            if (seed == 0) img[i] = (i == CH - 1);
            else img[i] = (((i * seed * 3) + (i / 5) + seed) % 7) < 3;
        end
    endtask

    task automatic clear_mon();
        en_cnt = 0; upd_cnt = 0; ar_cnt = 0; done_cnt = 0; err_cnt = 0;
        cap = '0; upd_en_low = 1'b0; busy_at_end = 1'b1;
        first_en = 0; last_en = 0; upd_cyc = 0; ar_cyc = 0; done_cyc = 0; err_cyc = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R10", int'(busy), 1);
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_cnt != 0 || err_cnt != 0) break;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic mismatches(output int n);
        n = 0;
        for (int i = 0; i < CH; i++) if (cap[i] !== img[i]) n++;
    endtask

    // seed, scan-done delay, lock delay, sticky
    localparam logic [24:0] VEC [5] = '{
        {8'd0, 8'd3, 8'd5, 1'b0},
        {8'd2, 8'd7, 8'd2, 1'b1},
        {8'd3, 8'd4, 8'd9, 1'b1},
        {8'd4, 8'd2, 8'd1, 1'b0},
        {8'd5, 8'd5, 8'd4, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int mm, exp_gap;
        bit stuck;
        clear_mon();
        load_image(1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, done, err, sen, upd, arst} == 6'b0, "R1",
              int'({busy, done, err, sen, upd, arst}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, done, err, sen, upd, arst} == 6'b0, "R1",
              int'({busy, done, err, sen, upd, arst}), 0);

        foreach (VEC[v]) begin
            load_image(int'(VEC[v][24:17]));
            sd_dly = int'(VEC[v][16:9]);
            lk_dly = int'(VEC[v][8:1]);
            sticky = VEC[v][0];
            stuck  = sticky && scandone;
            clear_mon();
            pulse_start();
            wait_end();
            check(en_cnt == CH, "R2", en_cnt, CH);
            check(last_en - first_en == CH - 1, "R2", last_en - first_en, CH - 1);
            mismatches(mm);
            check(mm == 0, "R3", mm, 0);
            check(upd_cnt == 1 && upd_cyc == last_en + 1 && upd_en_low, "R4",
                  upd_cyc - last_en, 1);
            exp_gap = stuck ? NW + 1 : sd_dly + 2;
            if (stuck) check(ar_cyc - upd_cyc == exp_gap, "R6", ar_cyc - upd_cyc, exp_gap);
            else       check(ar_cyc - upd_cyc == exp_gap, "R5", ar_cyc - upd_cyc, exp_gap);
            check(ar_cnt == 1, "R7", ar_cnt, 1);
            check(done_cnt == 1 && err_cnt == 0, "R8", done_cnt, 1);
            check(done_cyc - ar_cyc == lk_dly + 2, "R8", done_cyc - ar_cyc, lk_dly + 2);
            check(busy_at_end == 1'b0, "R8", int'(busy_at_end), 0);
        end

        // R10: start pulses during a run are ignored
        load_image(6); sd_dly = 3; lk_dly = 3; sticky = 1'b0;
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_end();
        repeat (300) @(negedge clk);
        check(en_cnt == CH, "R10", en_cnt, CH);
        check(done_cnt == 1, "R10", done_cnt, 1);
        check(busy == 1'b0, "R10", int'(busy), 0);

        // R9: lock never returns
        lk_dly = 0;
        clear_mon();
        pulse_start();
        wait_end();
        check(err_cnt == 1 && done_cnt == 0, "R9", err_cnt, 1);
        check(err_cyc - ar_cyc == TO + 1, "R9", err_cyc - ar_cyc, TO + 1);
        check(busy_at_end == 1'b0, "R9", int'(busy_at_end), 0);

        // R9: recovery run after an error
        lk_dly = 2; load_image(7);
        clear_mon();
        pulse_start();
        wait_end();
        mismatches(mm);
        check(done_cnt == 1 && err_cnt == 0 && mm == 0, "R9", done_cnt, 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule